// File: doc/BRIEF.md
# Automatic TX Packet Framer

The framer turns a payload waiting in a transmit FIFO into a complete over-the-air frame, delivered as a serial bit stream to a modulator. Once it sees a start strobe, it emits these sections in order: a run of preamble bytes, a sync word of one to four bytes, zero to four header bytes, an optional length byte, the payload bytes pulled one at a time from the FIFO, and an optional 16-bit CRC. Every field except the payload comes from configuration inputs. A packet therefore needs only the payload to be written and a single strobe to be given.

Bits leave most-significant first, one bit on each clock where the modulator's bit-enable input is high. Each bit appears on `tx_bit` together with a `tx_valid` strobe in the following cycle. The framer pauses, without emitting bits, whenever it needs a payload byte and the FIFO is empty. When the last bit is out, the framer raises a one-cycle completion pulse and returns to idle.

The configuration inputs must stay stable while a packet is in flight. The CRC shift register uses either the 0x1021 or the 0x8005 polynomial. It is preset to all ones, has no reflection and no output inversion, and covers the header, length and payload bytes.

Top module: `tx_frame_builder`

## Requirements
- R1: The frame is sent as preamble, sync, header, length byte, payload, CRC, in that order. A section configured empty (no header, length byte disabled, payload length 0, CRC disabled) is skipped without any gap bits.
- R2: The preamble consists of `cfg_pre_len` copies of the byte 0x55, so the first bit is 0 and ones and zeros alternate. A value of 0 is treated as 1.
- R3: `cfg_sync_len` code k (0..3) sends k+1 sync bytes taken from the low bytes of `cfg_sync_word`. Byte k (bits 8k+7:8k) goes first, then downward to byte 0. Higher bytes of the word are never sent.
- R4: `cfg_hdr_len` h sends min(h,4) header bytes from `cfg_hdr_bytes`. Byte min(h,4)-1 goes first, then downward to byte 0.
- R5: When `cfg_len_en`=1, a length byte equal to `cfg_pay_len` precedes the payload. When `cfg_len_en`=0, no length byte is sent. In both cases exactly `cfg_pay_len` payload bytes follow, taken from the FIFO in FIFO order.
- R6: When `cfg_crc_en`=1, two CRC bytes follow the payload, high byte first. `cfg_crc_sel`=0 selects polynomial 0x1021 and 1 selects 0x8005. The CRC is preset to 0xFFFF, is unreflected, has no final XOR, and covers the header, length and payload bytes. For the nine ASCII bytes "123456789" the two settings give 0x29B1 and 0xAEE7 respectively.
- R7: Each byte is sent MSB first. A bit is consumed only at a clock edge where `bit_en`=1, and it appears on `tx_bit` with `tx_valid`=1 in the next cycle. With `bit_en` held low, no bit is emitted.
- R8: `fifo_rd` pulses once per payload byte, on that byte's last bit, and never while `fifo_empty`=1. While a payload byte is needed and the FIFO is empty, no bit is emitted, and transmission resumes once the FIFO has data.
- R9: `pkt_sent` is high for exactly one cycle, the cycle right after the `tx_valid` cycle of the frame's last bit. After that the framer is idle.
- R10: A `start` pulse while a packet is in flight is ignored: the frame is unchanged and only one `pkt_sent` pulse occurs.
- R11: During and after reset, with no start given, `tx_valid`, `fifo_rd` and `pkt_sent` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (accepted only when idle) |
| bit_en | input | 1 | Modulator ready to take one bit this cycle |
| cfg_pre_len | input | PRE_W | Preamble length in bytes (0 treated as 1) |
| cfg_sync_len | input | clog2(SYNC_MAX) | Sync byte count minus one |
| cfg_sync_word | input | 8*SYNC_MAX | Sync pattern, low bytes used |
| cfg_hdr_len | input | clog2(HDR_MAX+1) | Header byte count, clamped to HDR_MAX |
| cfg_hdr_bytes | input | 8*HDR_MAX | Header bytes, low bytes used |
| cfg_len_en | input | 1 | Insert the length byte |
| cfg_pay_len | input | 8 | Payload length in bytes |
| cfg_crc_en | input | 1 | Append the CRC |
| cfg_crc_sel | input | 1 | 0: poly 0x1021, 1: poly 0x8005 |
| fifo_empty | input | 1 | FIFO has no data |
| fifo_data | input | 8 | Head-of-FIFO byte (show-ahead) |
| fifo_rd | output | 1 | Pop the head byte |
| tx_bit | output | 1 | Serial bit |
| tx_valid | output | 1 | `tx_bit` carries a new bit this cycle |
| pkt_sent | output | 1 | One-cycle end-of-packet pulse |

## Verification
Each bit is due one cycle after the edge at which `bit_en` was high, and `pkt_sent` is due exactly one cycle after the last `tx_valid` cycle. `fifo_rd` is combinational, so it is due in the cycle of a payload byte's eighth bit. The bench samples every output on the falling clock edge, stamps each captured bit and each `pkt_sent` with a cycle number, and compares the two stamps rather than waiting a fixed delay. This keeps the checks exact under irregular `bit_en` patterns and FIFO gaps. The captured bit stream is compared bit by bit with a frame the bench builds from the requirements, and two known CRC check values anchor the CRC independently of that model.

// File: rtl/tx_frame_builder.sv
module tx_frame_builder #(
  parameter int PRE_W = 8,
  parameter int SYNC_MAX = 4,
  parameter int HDR_MAX = 4,
  parameter logic [15:0] POLY_A = 16'h1021,
  parameter logic [15:0] POLY_B = 16'h8005,
  parameter logic [15:0] CRC_INIT = 16'hFFFF,
  localparam int SLW = $clog2(SYNC_MAX),
  localparam int HLW = $clog2(HDR_MAX + 1),
  localparam int BCW = (PRE_W > 8) ? PRE_W : 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  bit_en,
  input  logic [PRE_W-1:0]      cfg_pre_len,
  input  logic [SLW-1:0]        cfg_sync_len,
  input  logic [8*SYNC_MAX-1:0] cfg_sync_word,
  input  logic [HLW-1:0]        cfg_hdr_len,
  input  logic [8*HDR_MAX-1:0]  cfg_hdr_bytes,
  input  logic                  cfg_len_en,
  input  logic [7:0]            cfg_pay_len,
  input  logic                  cfg_crc_en,
  input  logic                  cfg_crc_sel,
  input  logic                  fifo_empty,
  input  logic [7:0]            fifo_data,
  output logic                  fifo_rd,
  output logic                  tx_bit,
  output logic                  tx_valid,
  output logic                  pkt_sent
);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SYNC, S_HDR, S_LEN, S_PAY, S_CRC} sec_t;

  sec_t           sec, nxt;
  logic [BCW-1:0] bytec, pre_n;
  logic [2:0]     bitc;
  logic [15:0]    crc, poly;
  logic           fin, step, last_byte, cur_bit, covered;
  logic [7:0]     cur_byte;
  logic [HLW-1:0] hdr_n, hdr_idx;
  logic [SLW-1:0] sync_idx;
  sec_t           after_pay, after_len, after_hdr, after_sync;

  assign pre_n    = (cfg_pre_len == '0) ? BCW'(1) : BCW'(cfg_pre_len);
  assign hdr_n    = (cfg_hdr_len > HLW'(HDR_MAX)) ? HLW'(HDR_MAX) : cfg_hdr_len;
  assign sync_idx = cfg_sync_len - bytec[SLW-1:0];
  assign hdr_idx  = hdr_n - HLW'(1) - bytec[HLW-1:0];
  assign poly     = cfg_crc_sel ? POLY_B : POLY_A;

  assign after_pay  = cfg_crc_en ? S_CRC : S_IDLE;
  assign after_len  = (cfg_pay_len != 8'd0) ? S_PAY : after_pay;
  assign after_hdr  = cfg_len_en ? S_LEN : after_len;
  assign after_sync = (hdr_n != '0) ? S_HDR : after_hdr;

  always_comb begin
    case (sec)
      S_PRE:   nxt = S_SYNC;
      S_SYNC:  nxt = after_sync;
      S_HDR:   nxt = after_hdr;
      S_LEN:   nxt = after_len;
      S_PAY:   nxt = after_pay;
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    case (sec)
      S_PRE:   cur_byte = 8'b0101_0101;
      S_SYNC:  cur_byte = cfg_sync_word[8*sync_idx +: 8];
      S_HDR:   cur_byte = cfg_hdr_bytes[8*hdr_idx +: 8];
      S_LEN:   cur_byte = cfg_pay_len;
      S_PAY:   cur_byte = fifo_data;
      S_CRC:   cur_byte = bytec[0] ? crc[7:0] : crc[15:8];
      default: cur_byte = 8'h00;
    endcase
  end

  always_comb begin
    case (sec)
      S_PRE:   last_byte = (bytec == pre_n - BCW'(1));
      S_SYNC:  last_byte = (bytec == BCW'(cfg_sync_len));
      S_HDR:   last_byte = (bytec == BCW'(hdr_n) - BCW'(1));
      S_LEN:   last_byte = 1'b1;
      S_PAY:   last_byte = (bytec == BCW'(cfg_pay_len) - BCW'(1));
      S_CRC:   last_byte = (bytec == BCW'(1));
      default: last_byte = 1'b0;
    endcase
  end

  assign cur_bit = cur_byte[3'd7 - bitc];
  assign covered = (sec == S_HDR) || (sec == S_LEN) || (sec == S_PAY);
  assign step    = (sec != S_IDLE) && bit_en && !((sec == S_PAY) && fifo_empty);
  assign fifo_rd = step && (sec == S_PAY) && (bitc == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec      <= S_IDLE;
      bytec    <= '0;
      bitc     <= '0;
      crc      <= CRC_INIT;
      fin      <= 1'b0;
      pkt_sent <= 1'b0;
      tx_bit   <= 1'b0;
      tx_valid <= 1'b0;
    end else begin
      tx_valid <= step;
      if (step) tx_bit <= cur_bit;
      fin      <= 1'b0;
      pkt_sent <= fin;
      if (sec == S_IDLE) begin
        if (start) begin
          sec   <= S_PRE;
          bytec <= '0;
          bitc  <= '0;
          crc   <= CRC_INIT;
        end
      end else if (step) begin
        if (covered) crc <= {crc[14:0], 1'b0} ^ ((crc[15] ^ cur_bit) ? poly : 16'h0000);
        bitc <= bitc + 3'd1;
        if (bitc == 3'd7) begin
          if (last_byte) begin
            sec   <= nxt;
            bytec <= '0;
            fin   <= (nxt == S_IDLE);
          end else begin
            bytec <= bytec + BCW'(1);
          end
        end
      end
    end
  end

  p_valid_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bit_en));

  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  p_sent_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_sent |=> !pkt_sent);

  p_sent_after_last_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_sent |-> ($past(tx_valid) && !tx_valid && sec != S_CRC));

  p_pre_starts_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec == S_PRE && bytec == '0 && bitc == 3'd0 && step) |=> !tx_bit);

  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec != S_IDLE && sec != S_PRE && start) |=> (sec != S_PRE));

endmodule

// File: tb/test_tx_frame_builder.sv
`timescale 1ns/1ps
module test_tx_frame_builder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic bit_en;
  logic [7:0]  cfg_pre_len = 8'd1;
  logic [1:0]  cfg_sync_len = 2'd0;
  logic [31:0] cfg_sync_word = 32'h0;
  logic [2:0]  cfg_hdr_len = 3'd0;
  logic [31:0] cfg_hdr_bytes = 32'h0;
  logic cfg_len_en = 1'b0, cfg_crc_en = 1'b0, cfg_crc_sel = 1'b0;
  logic [7:0]  cfg_pay_len = 8'd0;
  logic fifo_empty, fifo_rd, tx_bit, tx_valid, pkt_sent;
  logic [7:0] fifo_data;

  always #4 clk = ~clk;

  tx_frame_builder i_tx_frame_builder (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_en(bit_en),
    .cfg_pre_len(cfg_pre_len), .cfg_sync_len(cfg_sync_len), .cfg_sync_word(cfg_sync_word),
    .cfg_hdr_len(cfg_hdr_len), .cfg_hdr_bytes(cfg_hdr_bytes), .cfg_len_en(cfg_len_en),
    .cfg_pay_len(cfg_pay_len), .cfg_crc_en(cfg_crc_en), .cfg_crc_sel(cfg_crc_sel),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .pkt_sent(pkt_sent));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] fmem [0:255];
  int frd = 0, fcnt = 0;
  logic gap = 1'b0;
  int en_mode = 0, gap_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  assign fifo_empty = (frd >= fcnt) || gap;
  assign fifo_data  = fmem[frd[7:0]];

  always @(posedge clk) if (fifo_rd) frd <= frd + 1;

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    gap  <= (gap_mode != 0) ? (lfsr[3] & lfsr[5]) : 1'b0;
  end
  assign bit_en = (en_mode == 0) ? 1'b1 : (en_mode == 1) ? (lfsr[0] | lfsr[1]) : 1'b0;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic cap [0:4095];
  int cap_n = 0, last_v = -1, sent_n = 0, sent_cyc = -1;
  always @(negedge clk) begin
    if (tx_valid) begin cap[cap_n] = tx_bit; cap_n = cap_n + 1; last_v = cyc; end
    if (pkt_sent) begin sent_n = sent_n + 1; sent_cyc = cyc; end
  end

  logic expq [0:4095];
  int exp_n;
  logic [7:0] cov [0:511];
  int cov_n;

  task automatic chk(input bit ok, input string msg, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", msg, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] poly);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < cov_n; i++) begin
      c = c ^ {cov[i], 8'h00};
      for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

  task automatic push(input logic [7:0] b, input bit covd);
    for (int k = 7; k >= 0; k--) begin expq[exp_n] = b[k]; exp_n++; end
    if (covd) begin cov[cov_n] = b; cov_n++; end
  endtask

  task automatic build_exp();
    int pn, hn;
    logic [15:0] c;
    exp_n = 0; cov_n = 0;
    pn = (cfg_pre_len == 0) ? 1 : int'(cfg_pre_len);
    for (int i = 0; i < pn; i++) push(8'h55, 0);
    for (int i = int'(cfg_sync_len); i >= 0; i--) push(cfg_sync_word[8*i +: 8], 0);
    hn = (cfg_hdr_len > 3'd4) ? 4 : int'(cfg_hdr_len);
    for (int i = hn - 1; i >= 0; i--) push(cfg_hdr_bytes[8*i +: 8], 1);
    if (cfg_len_en) push(cfg_pay_len, 1);
    for (int i = 0; i < int'(cfg_pay_len); i++) push(fmem[i], 1);
    if (cfg_crc_en) begin
      c = ref_crc(cfg_crc_sel ? 16'h8005 : 16'h1021);
      push(c[15:8], 0); push(c[7:0], 0);
    end
  endtask

  // Sends one packet and checks stream, pops and completion pulse.
  task automatic run_pkt(input string tag, input bit busy_start, input bit hold_first);
    int t = 0, mism = -1;
    build_exp();
    @(negedge clk);
    cap_n = 0; sent_n = 0; last_v = -1; sent_cyc = -1;
    frd = 0; fcnt = int'(cfg_pay_len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (hold_first) begin
      repeat (40) @(negedge clk);
      chk(cap_n == 0, {tag, " R7 no bits while bit_en low"}, cap_n, 0);
      chk(frd == 0, {tag, " R8 no pop while bit_en low"}, frd, 0);
      en_mode = 0;
    end
    if (busy_start) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (sent_n == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (busy_start ? 40 : 4) @(negedge clk);
    chk(cap_n == exp_n, {tag, " R1 frame bit count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      if (mism < 0 && cap[i] !== expq[i]) mism = i;
    chk(mism < 0, {tag, " R1 first mismatching bit index"}, mism, -1);
    chk(sent_n == 1, {tag, " R9 pkt_sent pulse count"}, sent_n, 1);
    chk(sent_cyc == last_v + 1, {tag, " R9 pkt_sent cycle vs last bit"}, sent_cyc, last_v + 1);
    chk(frd == int'(cfg_pay_len), {tag, " R8 FIFO pops"}, frd, int'(cfg_pay_len));
  endtask

  task automatic crc_tail(input string tag, input logic [15:0] expv);
    logic [15:0] got = '0;
    for (int i = 0; i < 16; i++) got[15 - i] = (cap_n >= 16) ? cap[cap_n - 16 + i] : 1'b0;
    chk(got == expv, {tag, " R6 CRC check value"}, int'(got), int'(expv));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R11 tx_valid in reset", tx_valid, 0);
    chk(!pkt_sent, "R11 pkt_sent in reset", pkt_sent, 0);
    chk(!fifo_rd, "R11 fifo_rd in reset", fifo_rd, 0);
    rst_n = 1'b1;
    cap_n = 0; sent_n = 0;
    repeat (10) @(negedge clk);
    chk(cap_n == 0 && sent_n == 0, "R11 quiet without start", cap_n + sent_n, 0);
  endtask

  task automatic t_minimal();
    cfg_pre_len = 8'd1; cfg_sync_len = 2'd0; cfg_sync_word = 32'hFFFF_FF2D;
    cfg_hdr_len = 3'd0; cfg_len_en = 1'b0; cfg_pay_len = 8'd2; cfg_crc_en = 1'b0;
    fmem[0] = 8'hA5; fmem[1] = 8'h3C;
    en_mode = 0; gap_mode = 0;
    run_pkt("minimal R2 R3 R5 R7", 0, 0);
    chk(cap_n > 0 && cap[0] == 1'b0, "R2 first preamble bit", cap_n > 0 ? int'(cap[0]) : -1, 0);
  endtask

  task automatic t_full_ccitt();
    cfg_pre_len = 8'd3; cfg_sync_len = 2'd3; cfg_sync_word = 32'h2DD4_1234;
    cfg_hdr_len = 3'd4; cfg_hdr_bytes = 32'h1122_3344; cfg_len_en = 1'b1;
    cfg_pay_len = 8'd5; cfg_crc_en = 1'b1; cfg_crc_sel = 1'b0;
    for (int i = 0; i < 5; i++) fmem[i] = 8'(8'h60 + i * 7);
    en_mode = 1; gap_mode = 0;
    run_pkt("full R1 R4 R5 R6", 0, 0);
  endtask

  task automatic t_ibm_short();
    cfg_pre_len = 8'd0; cfg_sync_len = 2'd1; cfg_sync_word = 32'hFFFF_AB12;
    cfg_hdr_len = 3'd2; cfg_hdr_bytes = 32'hEEEE_C0DE; cfg_len_en = 1'b0;
    cfg_pay_len = 8'd3; cfg_crc_en = 1'b1; cfg_crc_sel = 1'b1;
    fmem[0] = 8'h00; fmem[1] = 8'hFF; fmem[2] = 8'h81;
    en_mode = 1; gap_mode = 0;
    run_pkt("ibm R2 R3 R4 R6", 0, 0);
  endtask

  task automatic t_fifo_gaps();
    cfg_pre_len = 8'd2; cfg_sync_len = 2'd2; cfg_sync_word = 32'h00AB_CDEF;
    cfg_hdr_len = 3'd6; cfg_hdr_bytes = 32'hDEAD_BEEF; cfg_len_en = 1'b1;
    cfg_pay_len = 8'd6; cfg_crc_en = 1'b1; cfg_crc_sel = 1'b0;
    for (int i = 0; i < 6; i++) fmem[i] = 8'(8'h13 * (i + 1));
    en_mode = 0; gap_mode = 1;
    run_pkt("gaps R8 R4 clamp", 0, 0);
    gap_mode = 0;
  endtask

  task automatic t_busy_start_empty_payload();
    cfg_pre_len = 8'd2; cfg_sync_len = 2'd0; cfg_sync_word = 32'h0000_0099;
    cfg_hdr_len = 3'd1; cfg_hdr_bytes = 32'h0000_0042; cfg_len_en = 1'b1;
    cfg_pay_len = 8'd0; cfg_crc_en = 1'b1; cfg_crc_sel = 1'b1;
    en_mode = 0;
    run_pkt("busy R10 R5 empty payload", 1, 0);
  endtask

  task automatic t_anchor(input bit sel, input logic [15:0] expv);
    string s = "123456789";
    cfg_pre_len = 8'd1; cfg_sync_len = 2'd0; cfg_sync_word = 32'h0000_00AA;
    cfg_hdr_len = 3'd0; cfg_len_en = 1'b0; cfg_pay_len = 8'd9;
    cfg_crc_en = 1'b1; cfg_crc_sel = sel;
    for (int i = 0; i < 9; i++) fmem[i] = s[i];
    en_mode = 1;
    run_pkt(sel ? "anchor ibm R6" : "anchor ccitt R6", 0, 0);
    crc_tail(sel ? "anchor ibm" : "anchor ccitt", expv);
  endtask

  task automatic t_hold();
    cfg_pre_len = 8'd1; cfg_sync_len = 2'd0; cfg_sync_word = 32'h0000_0071;
    cfg_hdr_len = 3'd0; cfg_len_en = 1'b1; cfg_pay_len = 8'd2; cfg_crc_en = 1'b0;
    fmem[0] = 8'h5A; fmem[1] = 8'hC3;
    en_mode = 2;
    run_pkt("hold R7", 0, 1);
  endtask

  initial begin
    t_reset();
    t_minimal();
    t_full_ccitt();
    t_ibm_short();
    t_fifo_gaps();
    t_busy_start_empty_payload();
    t_anchor(1'b0, 16'h29B1);
    t_anchor(1'b1, 16'hAEE7);
    t_hold();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule